// File: doc/BRIEF.md
# Receive Label Filter Memory

This block holds a small table of eight-bit label values for one receive channel of a 32-bit serial data bus. It decides, for every received word, whether the word is kept or thrown away. A host fills and inspects the table over a byte-wide bus. It does not address the table directly. Instead, it raises a label-mode control bit and then issues a fixed burst of strobes. The burst walks the entries from first to last, so no address bus is needed.

In normal operation the block watches a valid pulse from the receiver. The receiver also supplies the label field, which is the low eight bits of the received word. One cycle after the valid pulse, the block raises either an accept pulse or a discard pulse. When recognition is switched off, every word is accepted. Reception is held off while the table is being loaded, so that a half-written table never screens traffic.

A sequencer state machine owns the burst. Its states and transitions are:

- **IDLE**: no burst is running.
- **ARMED**: entered from any state on a 0-to-1 edge of the mode bit. The counter is cleared here.
- **LOAD**: entered from ARMED on the first accepted write.
- **DUMP**: entered from ARMED on the first accepted read.
- **SPENT**: entered from LOAD or DUMP, or directly from ARMED when there is one entry, on the access that uses the last entry.
- **Back to IDLE**: happens from any state whenever the mode bit is low.

Top module: `rx_label_screen`

## Requirements
- R1: A 0-to-1 change of `lbl_mode`, seen at a clock edge, arms a new access burst and sets the entry counter to 0. Strobes in that same cycle are ignored.
- R2: With the burst armed, each cycle that has `host_wr`=1 and `byte_sel`=1 stores `host_din` into the next entry, starting at entry 0 and going up by one each time.
- R3: After the 16th access the counter wraps to 0 and the burst stops. Later strobes change neither the table nor `host_dout` until `lbl_mode` is raised again.
- R4: With the burst armed, each cycle that has `host_rd`=1 and `byte_sel`=1 returns the next entry, in the same order, on `host_dout`. The value appears one cycle after the strobe and is held until the next accepted read.
- R5: A strobe with `byte_sel`=0, or any strobe while `lbl_mode`=0, leaves the table and the counter unchanged.
- R6: Bit i of `rx_label` is compared with bit i of each stored entry, for i = 0 to 7. A match with any entry gives `rx_accept`=1 in the cycle after `rx_valid`. `rx_accept` and `rx_discard` are never high together.
- R7: With `recog_en`=0, every valid word that is not suspended gives `rx_accept`=1 one cycle later.
- R8: With `recog_en`=1, a valid word that matches no entry gives `rx_discard`=1 and `rx_accept`=0 one cycle later.
- R9: The label value 0x00 matches like any other value.
- R10: From arming until the burst ends, a write burst holds `rx_suspended`=1. Words that arrive during that time produce neither pulse.
- R11: After reset all entries are 0x00, the sequencer is in IDLE, and all outputs are 0.
- R12: Clearing `lbl_mode` returns the sequencer to IDLE from any state, and reception resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lbl_mode | input | 1 | Label access mode; its rising edge starts a burst |
| recog_en | input | 1 | Label recognition enable |
| byte_sel | input | 1 | Byte select; must be 1 for table access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_din | input | 8 | Label byte written by the host |
| host_dout | output | 8 | Label byte read back, registered |
| rx_valid | input | 1 | One-cycle pulse: a received word is ready |
| rx_label | input | 8 | Low eight bits of the received word |
| rx_accept | output | 1 | Word kept, one cycle after `rx_valid` |
| rx_discard | output | 1 | Word dropped, one cycle after `rx_valid` |
| rx_suspended | output | 1 | Reception held off during a write burst |

## Verification
The bench loads a table of deliberately skewed labels, including 0x00, 0x01 and 0x80, and then sweeps all 256 label values with recognition on and with it off. A reversed bit order or a missed entry in the comparison would turn some of the sweep's accepts into discards, or the other way round. Strobes with byte select low, a 17th strobe and writes outside label mode are mixed into the bursts. A counter that advanced on those strobes, or that failed to stop, would show up as shifted or overwritten bytes on readback. Words sent while a burst is armed and while it is loading would leak through a missing suspend. A mode bit dropped in the middle of a burst checks the return to IDLE.

// File: rtl/rx_label_pkg.sv
package rx_label_pkg;

    typedef enum logic [2:0] {
        LS_IDLE  = 3'd0,
        LS_ARMED = 3'd1,
        LS_LOAD  = 3'd2,
        LS_DUMP  = 3'd3,
        LS_SPENT = 3'd4
    } lbl_state_t;

endpackage

// File: rtl/lbl_seq_ctrl.sv
module lbl_seq_ctrl
    import rx_label_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode,
    input  logic             wr_stb,
    input  logic             rd_stb,
    input  logic             byte_sel,
    output logic             wr_en,
    output logic             rd_en,
    output logic [IDX_W-1:0] idx,
    output logic             suspend
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    lbl_state_t      state, state_nxt;
    logic [IDX_W-1:0] cnt, cnt_nxt;
    logic            mode_q;
    logic            rise;
    logic            wr_ok, rd_ok;
    logic            step;
    logic            at_last;

    assign rise    = mode & ~mode_q;
    assign wr_ok   = mode & ~rise & byte_sel & wr_stb;
    assign rd_ok   = mode & ~rise & byte_sel & rd_stb;
    assign at_last = (cnt == LAST_IDX);

    // next state
    always_comb begin
        state_nxt = state;
        if (!mode) begin
            state_nxt = LS_IDLE;
        end else if (rise) begin
            state_nxt = LS_ARMED;
        end else begin
            unique case (state)
                LS_IDLE:  state_nxt = LS_IDLE;
                LS_ARMED: begin
                    if (wr_ok)      state_nxt = at_last ? LS_SPENT : LS_LOAD;
                    else if (rd_ok) state_nxt = at_last ? LS_SPENT : LS_DUMP;
                end
                LS_LOAD:  if (wr_ok && at_last) state_nxt = LS_SPENT;
                LS_DUMP:  if (rd_ok && at_last) state_nxt = LS_SPENT;
                LS_SPENT: state_nxt = LS_SPENT;
                default:  state_nxt = LS_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en   = 1'b0;
        rd_en   = 1'b0;
        suspend = 1'b0;
        unique case (state)
            LS_IDLE:  ;
            LS_ARMED: begin
                wr_en   = wr_ok;
                rd_en   = rd_ok & ~wr_ok;
                suspend = 1'b1;
            end
            LS_LOAD: begin
                wr_en   = wr_ok;
                suspend = 1'b1;
            end
            LS_DUMP:  rd_en = rd_ok;
            LS_SPENT: ;
            default:  ;
        endcase
        if (!mode) begin
            suspend = 1'b0;
        end
        idx  = cnt;
        step = wr_en | rd_en;
    end

    always_comb begin
        if (!mode || rise)  cnt_nxt = '0;
        else if (step)      cnt_nxt = at_last ? '0 : cnt + 1'b1;
        else                cnt_nxt = cnt;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= LS_IDLE;
            cnt    <= '0;
            mode_q <= 1'b0;
        end else begin
            state  <= state_nxt;
            cnt    <= cnt_nxt;
            mode_q <= mode;
        end
    end

    AST_RISE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !mode_q) |=> (state == LS_ARMED && cnt == '0)); // R1
    AST_LAST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_last) |=> (state == LS_SPENT && cnt == '0)); // R3
    AST_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |=> (state == LS_IDLE)); // R12
    AST_SEL_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && mode_q && !byte_sel) |=> $stable(cnt)); // R5

endmodule

// File: rtl/lbl_store.sv
module lbl_store #(
    parameter int NUM_ENTRIES = 16,
    parameter int LABEL_W = 8,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic                                rd_en,
    input  logic [IDX_W-1:0]                    idx,
    input  logic [LABEL_W-1:0]                  wr_data,
    output logic [LABEL_W-1:0]                  rd_data,
    output logic [NUM_ENTRIES-1:0][LABEL_W-1:0] entries
);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entries[g] <= '0;
            end else if (wr_en && idx == IDX_W'(g)) begin
                entries[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= entries[idx];
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (entries[$past(idx)] == $past(wr_data))); // R2
    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R4

endmodule

// File: rtl/lbl_match.sv
module lbl_match #(
    parameter int NUM_ENTRIES = 16,
    parameter int LABEL_W = 8
) (
    input  logic [NUM_ENTRIES-1:0][LABEL_W-1:0] entries,
    input  logic [LABEL_W-1:0]                  key,
    output logic                                hit
);

    logic [NUM_ENTRIES-1:0] eq;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign eq[g] = (entries[g] == key);
    end

    assign hit = |eq;

endmodule

// File: rtl/rx_label_screen.sv
module rx_label_screen #(
    parameter int NUM_ENTRIES = 16,
    parameter int LABEL_W = 8,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lbl_mode,
    input  logic               recog_en,
    input  logic               byte_sel,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [LABEL_W-1:0] host_din,
    output logic [LABEL_W-1:0] host_dout,
    input  logic               rx_valid,
    input  logic [LABEL_W-1:0] rx_label,
    output logic               rx_accept,
    output logic               rx_discard,
    output logic               rx_suspended
);

    logic                                wr_en, rd_en, suspend, hit;
    logic [IDX_W-1:0]                    idx;
    logic [NUM_ENTRIES-1:0][LABEL_W-1:0] entries;

    lbl_seq_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (lbl_mode),
        .wr_stb   (host_wr),
        .rd_stb   (host_rd),
        .byte_sel (byte_sel),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .idx      (idx),
        .suspend  (suspend)
    );

    lbl_store #(.NUM_ENTRIES(NUM_ENTRIES), .LABEL_W(LABEL_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .idx     (idx),
        .wr_data (host_din),
        .rd_data (host_dout),
        .entries (entries)
    );

    lbl_match #(.NUM_ENTRIES(NUM_ENTRIES), .LABEL_W(LABEL_W)) u_match (
        .entries (entries),
        .key     (rx_label),
        .hit     (hit)
    );

    assign rx_suspended = suspend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_accept  <= 1'b0;
            rx_discard <= 1'b0;
        end else if (rx_valid && !suspend) begin
            rx_accept  <= ~recog_en | hit;
            rx_discard <= recog_en & ~hit;
        end else begin
            rx_accept  <= 1'b0;
            rx_discard <= 1'b0;
        end
    end

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_accept, rx_discard})); // R6
    AST_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_suspended) |=> (!rx_accept && !rx_discard)); // R10
    AST_OPEN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_suspended && !recog_en) |=> rx_accept); // R7
    AST_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> (!rx_accept && !rx_discard)); // R8

endmodule

// File: tb/rx_label_screen_bench.sv
module rx_label_screen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NUM = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lbl_mode = 1'b0, recog_en = 1'b0, byte_sel = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_din = '0;
    logic [7:0] host_dout;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_label = '0;
    logic       rx_accept, rx_discard, rx_suspended;

    int total = 0;
    int bad = 0;
    logic [7:0] lab [NUM];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_label_screen u_rx_label_screen (
        .clk(clk), .rst_n(rst_n), .lbl_mode(lbl_mode), .recog_en(recog_en),
        .byte_sel(byte_sel), .host_wr(host_wr), .host_rd(host_rd),
        .host_din(host_din), .host_dout(host_dout), .rx_valid(rx_valid),
        .rx_label(rx_label), .rx_accept(rx_accept), .rx_discard(rx_discard),
        .rx_suspended(rx_suspended)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic v);
        @(negedge clk); lbl_mode = v;
        @(negedge clk);
    endtask

    task automatic hwrite(input logic [7:0] d, input logic sel);
        @(negedge clk); host_wr = 1'b1; host_din = d; byte_sel = sel;
        @(negedge clk); host_wr = 1'b0; byte_sel = 1'b0;
    endtask

    task automatic hread(output logic [7:0] v);
        @(negedge clk); host_rd = 1'b1; byte_sel = 1'b1;
        @(negedge clk); host_rd = 1'b0; byte_sel = 1'b0;
        v = host_dout;
    endtask

    task automatic send(input logic [7:0] k, output logic acc, output logic dis);
        @(negedge clk); rx_valid = 1'b1; rx_label = k;
        @(negedge clk); rx_valid = 1'b0;
        acc = rx_accept; dis = rx_discard;
    endtask

    function automatic logic in_table(input logic [7:0] k);
        for (int i = 0; i < NUM; i++) if (lab[i] == k) return 1'b1;
        return 1'b0;
    endfunction

    initial begin
        logic [7:0] v;
        logic a, d;
        for (int i = 0; i < NUM; i++) lab[i] = 8'((i * 29 + 3) & 8'hFF);
        lab[6] = 8'h00; lab[9] = 8'h80; lab[10] = 8'h01;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 accept", int'(rx_accept), 0);
        check("R11 discard", int'(rx_discard), 0);
        check("R11 dout", int'(host_dout), 0);
        check("R11 suspended", int'(rx_suspended), 0);
        recog_en = 1'b1;
        send(8'h00, a, d);
        check("R11 R9 zero table matches 0x00", int'(a), 1);
        send(8'h80, a, d);
        check("R8 no match discards", int'({a, d}), 1);

        // R5 write outside label mode
        hwrite(8'hAA, 1'b1);
        send(8'hAA, a, d);
        check("R5 write outside mode ignored", int'({a, d}), 1);

        // load burst with noise
        set_mode(1'b1);
        check("R10 suspended when armed", int'(rx_suspended), 1);
        send(8'h00, a, d);
        check("R10 armed word dropped", int'({a, d}), 0);
        for (int i = 0; i < NUM; i++) begin
            hwrite(8'h5A ^ 8'(i), 1'b0);   // byte_sel low: R5
            hwrite(lab[i], 1'b1);           // R2
            if (i == 7) begin
                send(lab[0], a, d);
                check("R10 loading word dropped", int'({a, d}), 0);
            end
        end
        check("R3 suspend ends after last write", int'(rx_suspended), 0);
        hwrite(8'hEE, 1'b1);                // 17th write ignored: R3

        // readback
        set_mode(1'b0);
        set_mode(1'b1);                     // R1 re-arm
        for (int i = 0; i < NUM; i++) begin
            hread(v);
            check($sformatf("R4 R2 readback entry %0d", i), int'(v), int'(lab[i]));
        end
        hread(v);
        check("R3 extra read ignored", int'(v), int'(lab[NUM-1]));

        // R12: drop mode mid burst
        set_mode(1'b0);
        set_mode(1'b1);
        hwrite(lab[0], 1'b1);
        set_mode(1'b0);
        check("R12 idle after mode cleared", int'(rx_suspended), 0);
        send(lab[3], a, d);
        check("R12 reception resumes", int'({a, d}), 2);

        // sweeps
        recog_en = 1'b1;
        for (int k = 0; k < 256; k++) begin
            send(8'(k), a, d);
            check($sformatf("R6 R8 R9 sweep %02h", k), int'({a, d}),
                  in_table(8'(k)) ? 2 : 1);
        end
        recog_en = 1'b0;
        for (int k = 0; k < 256; k++) begin
            send(8'(k), a, d);
            check($sformatf("R7 open sweep %02h", k), int'({a, d}), 2);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule